// File: doc/BRIEF.md
# DMA Descriptor Dispatcher

This block sits between a host processor and a pair of data movers. The host hands it transfer descriptors, and each descriptor names a source address, a destination address, a byte length and a control byte. The block holds them in an in-order queue. It takes one descriptor at a time and turns it into two commands. A read command, carrying the source address and the length, goes to a read engine. A write command, carrying the destination address and the length, goes to a write engine.

When both engines have reported completion, the block emits a single response for that descriptor. The response carries the length and the two error flags. Only then does the next descriptor start.

A small register port serves several purposes. The host uses it to read status and the queue fill level. It also uses it to enable the completion interrupt, to acknowledge that interrupt and to start a software reset. The software reset clears the block over a fixed number of cycles, and a status bit can be polled to see when the reset has finished.

Top module: `dma_dispatch`

## Requirements
- R1: A descriptor is accepted (`desc_ready` high) only when the queue holds fewer than DEPTH (8) entries and no software reset is running; with 8 entries queued, `desc_ready` is low and STATUS bit 2 (full) reads 1.
- R2: For each descriptor exactly one read command is issued with the descriptor's read address and length, and exactly one write command with its write address and length; each command valid stays high with stable fields until accepted.
- R3: Only one descriptor is in flight: no command for the next descriptor is issued until the current descriptor's response has been accepted.
- R4: A response is produced only after both the read and the write completion have arrived; `resp_len` equals the descriptor length and `resp_err` bit 0 is the read error and bit 1 the write error.
- R5: Descriptors are executed and responded to in the order they were accepted.
- R6: `irq` goes high after the response of a descriptor whose control bit 0 is 1 is accepted while CONTROL bit 0 (interrupt enable) is 1; it stays high until 1 is written to STATUS bit 3, and it stays low for descriptors without the bit or while interrupts are disabled. STATUS bit 3 mirrors `irq`.
- R7: Writing 1 to CONTROL bit 1 starts a software reset: STATUS bit 4 reads 1 for RST_CYC (4) cycles starting with the cycle after the write, then 0; afterwards the queue is empty, the pending interrupt is cleared, and CONTROL reads 0.
- R8: CSR address 0 is STATUS (bit 0 busy, bit 1 queue empty, bit 2 full, bit 3 interrupt pending, bit 4 resetting), address 1 is CONTROL (bit 0 interrupt enable), and address 2 returns the queue fill level.
- R9: After hardware reset STATUS reads 0x2 (empty only), `irq` is low and `desc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| csr_addr | input | 2 | Register address |
| csr_wen | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| desc_valid | input | 1 | Descriptor valid |
| desc_ready | output | 1 | Descriptor accepted |
| desc_raddr | input | 32 | Descriptor read address |
| desc_waddr | input | 32 | Descriptor write address |
| desc_len | input | 32 | Descriptor length |
| desc_ctl | input | 8 | Descriptor control, bit 0 interrupt on completion |
| rcmd_valid | output | 1 | Read command valid |
| rcmd_ready | input | 1 | Read command accepted |
| rcmd_addr | output | 32 | Read command address |
| rcmd_len | output | 32 | Read command length |
| wcmd_valid | output | 1 | Write command valid |
| wcmd_ready | input | 1 | Write command accepted |
| wcmd_addr | output | 32 | Write command address |
| wcmd_len | output | 32 | Write command length |
| rrsp_valid | input | 1 | Read completion pulse |
| rrsp_err | input | 1 | Read completion error |
| wrsp_valid | input | 1 | Write completion pulse |
| wrsp_err | input | 1 | Write completion error |
| resp_valid | output | 1 | Descriptor response valid |
| resp_ready | input | 1 | Descriptor response accepted |
| resp_len | output | 32 | Response length |
| resp_err | output | 2 | Response errors {write, read} |
| irq | output | 1 | Level interrupt |

## Verification
First, a stalled response sink with always-ready engines fills the queue to its limit. This exposes full and back-pressure faults, and it shows whether commands leak out while a response is outstanding. The software reset is then applied with that full queue, so the test can tell whether the resetting bit lasts the right number of cycles and whether the reset truly clears the queue and the control register. Directed single descriptors with the interrupt bit and the enable each set and cleared separate interrupt set, hold and clear faults. Random engine ready, random completion delays, random error flags and random sink ready then test ordering, and they test which address and error goes to which side of the split and join.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int DD_AW = 32;
  localparam int DD_LW = 32;
  localparam int DD_CW = 8;

  typedef struct packed {
    logic [DD_AW-1:0] raddr;
    logic [DD_AW-1:0] waddr;
    logic [DD_LW-1:0] len;
    logic [DD_CW-1:0] ctl;
  } desc_t;

  localparam logic [1:0] CSR_STATUS = 2'd0;
  localparam logic [1:0] CSR_CTRL   = 2'd1;
  localparam logic [1:0] CSR_LEVEL  = 2'd2;

  localparam int ST_BUSY = 0;
  localparam int ST_EMPTY = 1;
  localparam int ST_FULL = 2;
  localparam int ST_IRQ = 3;
  localparam int ST_RST = 4;
  localparam int CT_IEN = 0;
  localparam int CT_SRST = 1;
  localparam int DC_IRQ = 0;

  function automatic logic [31:0] status_word(input logic busy, input logic empty,
                                              input logic full, input logic pend,
                                              input logic rst);
    logic [31:0] w;
    w = '0;
    w[ST_BUSY]  = busy;
    w[ST_EMPTY] = empty;
    w[ST_FULL]  = full;
    w[ST_IRQ]   = pend;
    w[ST_RST]   = rst;
    return w;
  endfunction
endpackage

// File: rtl/dd_queue.sv
module dd_queue
  import dd_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          push,
  input  desc_t         din,
  input  logic          pop,
  output desc_t         dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  desc_t mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (srst) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push) wp <= ptr_inc(wp);
      if (pop)  rp <= ptr_inc(rp);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/dd_seq.sv
module dd_seq
  import dd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             q_empty,
  input  desc_t            q_head,
  output logic             q_pop,
  output logic             rcmd_valid,
  input  logic             rcmd_ready,
  output logic [DD_AW-1:0] rcmd_addr,
  output logic [DD_LW-1:0] rcmd_len,
  output logic             wcmd_valid,
  input  logic             wcmd_ready,
  output logic [DD_AW-1:0] wcmd_addr,
  output logic [DD_LW-1:0] wcmd_len,
  input  logic             rrsp_valid,
  input  logic             rrsp_err,
  input  logic             wrsp_valid,
  input  logic             wrsp_err,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [DD_LW-1:0] resp_len,
  output logic [1:0]       resp_err,
  output logic             busy,
  output logic             done_evt,
  output logic             done_irq
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_RESP} st_t;
  st_t   state;
  desc_t cur;
  logic  rc_ok, wc_ok, rr_ok, wr_ok, rr_e, wr_e;
  logic  unused_ctl;

  assign unused_ctl = ^cur.ctl;
  assign busy       = (state != S_IDLE);
  assign q_pop      = (state == S_IDLE) && !q_empty && !srst;
  assign rcmd_valid = (state == S_RUN) && !rc_ok;
  assign wcmd_valid = (state == S_RUN) && !wc_ok;
  assign rcmd_addr  = cur.raddr;
  assign wcmd_addr  = cur.waddr;
  assign rcmd_len   = cur.len;
  assign wcmd_len   = cur.len;
  assign resp_valid = (state == S_RESP);
  assign resp_len   = cur.len;
  assign resp_err   = {wr_e, rr_e};
  assign done_evt   = resp_valid && resp_ready;
  assign done_irq   = cur.ctl[DC_IRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cur <= '0;
      {rc_ok, wc_ok, rr_ok, wr_ok, rr_e, wr_e} <= '0;
    end else if (srst) begin
      state <= S_IDLE;
      {rc_ok, wc_ok, rr_ok, wr_ok, rr_e, wr_e} <= '0;
    end else begin
      case (state)
        S_IDLE: if (q_pop) begin
          cur <= q_head;
          {rc_ok, wc_ok, rr_ok, wr_ok, rr_e, wr_e} <= '0;
          state <= S_RUN;
        end
        S_RUN: begin
          if (rcmd_valid && rcmd_ready) rc_ok <= 1'b1;
          if (wcmd_valid && wcmd_ready) wc_ok <= 1'b1;
          if (rrsp_valid && !rr_ok) begin rr_ok <= 1'b1; rr_e <= rrsp_err; end
          if (wrsp_valid && !wr_ok) begin wr_ok <= 1'b1; wr_e <= wrsp_err; end
          if (rc_ok && wc_ok && rr_ok && wr_ok) state <= S_RESP;
        end
        S_RESP: if (resp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  rcmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    rcmd_valid && !rcmd_ready |=> rcmd_valid && $stable(rcmd_addr) && $stable(rcmd_len));
  // R2
  wcmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    wcmd_valid && !wcmd_ready |=> wcmd_valid && $stable(wcmd_addr) && $stable(wcmd_len));
  // R3
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    resp_valid && !resp_ready |=> !rcmd_valid && !wcmd_valid);
endmodule

// File: rtl/dma_dispatch.sv
module dma_dispatch
  import dd_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int RST_CYC = 4,
  localparam int LW  = $clog2(DEPTH + 1),
  localparam int RCW = $clog2(RST_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       csr_addr,
  input  logic             csr_wen,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [DD_AW-1:0] desc_raddr,
  input  logic [DD_AW-1:0] desc_waddr,
  input  logic [DD_LW-1:0] desc_len,
  input  logic [DD_CW-1:0] desc_ctl,
  output logic             rcmd_valid,
  input  logic             rcmd_ready,
  output logic [DD_AW-1:0] rcmd_addr,
  output logic [DD_LW-1:0] rcmd_len,
  output logic             wcmd_valid,
  input  logic             wcmd_ready,
  output logic [DD_AW-1:0] wcmd_addr,
  output logic [DD_LW-1:0] wcmd_len,
  input  logic             rrsp_valid,
  input  logic             rrsp_err,
  input  logic             wrsp_valid,
  input  logic             wrsp_err,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [DD_LW-1:0] resp_len,
  output logic [1:0]       resp_err,
  output logic             irq
);
  desc_t q_in, q_head;
  logic q_empty, q_full, q_pop, q_push;
  logic [LW-1:0] q_level;
  logic busy, done_evt, done_irq;
  logic ien, pend, resetting, srst_req, ack_req;
  logic [RCW-1:0] rst_cnt;
  logic unused_wdata;

  assign unused_wdata = ^csr_wdata[31:5];
  assign resetting = (rst_cnt != '0);
  assign srst_req  = csr_wen && (csr_addr == CSR_CTRL) && csr_wdata[CT_SRST];
  assign ack_req   = csr_wen && (csr_addr == CSR_STATUS) && csr_wdata[ST_IRQ];
  assign desc_ready = !q_full && !resetting;
  assign q_push    = desc_valid && desc_ready;
  assign q_in      = '{raddr: desc_raddr, waddr: desc_waddr, len: desc_len, ctl: desc_ctl};
  assign irq       = pend;

  dd_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .srst(resetting), .push(q_push), .din(q_in),
    .pop(q_pop), .dout(q_head), .empty(q_empty), .full(q_full), .level(q_level)
  );

  dd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .srst(resetting), .q_empty(q_empty), .q_head(q_head),
    .q_pop(q_pop), .rcmd_valid(rcmd_valid), .rcmd_ready(rcmd_ready),
    .rcmd_addr(rcmd_addr), .rcmd_len(rcmd_len), .wcmd_valid(wcmd_valid),
    .wcmd_ready(wcmd_ready), .wcmd_addr(wcmd_addr), .wcmd_len(wcmd_len),
    .rrsp_valid(rrsp_valid), .rrsp_err(rrsp_err), .wrsp_valid(wrsp_valid),
    .wrsp_err(wrsp_err), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_len(resp_len), .resp_err(resp_err), .busy(busy), .done_evt(done_evt),
    .done_irq(done_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= 1'b0; pend <= 1'b0; rst_cnt <= '0;
    end else begin
      if (srst_req) rst_cnt <= RCW'(RST_CYC);
      else if (resetting) rst_cnt <= rst_cnt - 1'b1;
      if (resetting) begin
        ien <= 1'b0; pend <= 1'b0;
      end else begin
        if (csr_wen && csr_addr == CSR_CTRL) ien <= csr_wdata[CT_IEN];
        if (ack_req) pend <= 1'b0;
        if (done_evt && done_irq && ien) pend <= 1'b1;
      end
    end
  end

  always_comb begin
    case (csr_addr)
      CSR_STATUS: csr_rdata = status_word(busy, q_empty, q_full, pend, resetting);
      CSR_CTRL:   csr_rdata = {31'b0, ien};
      CSR_LEVEL:  csr_rdata = 32'(q_level);
      default:    csr_rdata = '0;
    endcase
  end

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_evt && ien));
  // R7
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetting) |-> $past(srst_req));
  // R7
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetting && $past(resetting) |-> !resp_valid && !rcmd_valid && !wcmd_valid && q_empty && !irq);
endmodule

// File: tb/sim_dma_dispatch.sv
module sim_dma_dispatch;
  localparam int CLK_P = 10;
  localparam int NSB = 256;

  logic clk = 0, rst_n = 0;
  logic [1:0] csr_addr = 0; logic csr_wen = 0; logic [31:0] csr_wdata = 0, csr_rdata;
  logic desc_valid = 0, desc_ready;
  logic [31:0] desc_raddr = 0, desc_waddr = 0, desc_len = 0; logic [7:0] desc_ctl = 0;
  logic rcmd_valid, rcmd_ready; logic [31:0] rcmd_addr, rcmd_len;
  logic wcmd_valid, wcmd_ready; logic [31:0] wcmd_addr, wcmd_len;
  logic rrsp_valid, rrsp_err, wrsp_valid, wrsp_err;
  logic resp_valid, resp_ready; logic [31:0] resp_len; logic [1:0] resp_err;
  logic irq;

  int n_chk = 0, n_fail = 0;
  int push_cnt = 0, rd_idx = 0, wr_idx = 0, rsp_idx = 0, r_back = 0, w_back = 0;
  bit fast = 1, hold_resp = 0, done = 0;
  logic [31:0] e_ra [NSB]; logic [31:0] e_wa [NSB]; logic [31:0] e_ln [NSB];
  bit e_re [NSB]; bit e_we [NSB];

  always #(CLK_P/2) clk = ~clk;

  dma_dispatch u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(bit busy, bit empty, bit full, bit pend, bit rst);
    return (32'(rst) << 4) | (32'(pend) << 3) | (32'(full) << 2) | (32'(empty) << 1) | 32'(busy);
  endfunction

  // read engine model
  initial begin
    int pend_r = 0;
    rcmd_ready = 0; rrsp_valid = 0; rrsp_err = 0;
    forever begin
      @(negedge clk);
      rrsp_valid = 0;
      if (pend_r > 0) begin
        pend_r--;
        if (pend_r == 0) begin
          rrsp_valid = 1; rrsp_err = ($urandom % 4) == 0;
          e_re[(rd_idx-1) % NSB] = rrsp_err; r_back++;
        end
      end
      rcmd_ready = fast ? 1'b1 : 1'($urandom % 2);
      #1;
      if (rcmd_valid && rcmd_ready) begin
        chk(rcmd_addr == e_ra[rd_idx % NSB], "R2 rd addr", rcmd_addr, e_ra[rd_idx % NSB]);
        chk(rcmd_len == e_ln[rd_idx % NSB], "R2 rd len", rcmd_len, e_ln[rd_idx % NSB]);
        chk(rd_idx == rsp_idx, "R3 rd cmd while prior open", rd_idx, rsp_idx);
        rd_idx++; pend_r = 1 + int'($urandom % 4);
      end
    end
  end

  // write engine model
  initial begin
    int pend_w = 0;
    wcmd_ready = 0; wrsp_valid = 0; wrsp_err = 0;
    forever begin
      @(negedge clk);
      wrsp_valid = 0;
      if (pend_w > 0) begin
        pend_w--;
        if (pend_w == 0) begin
          wrsp_valid = 1; wrsp_err = ($urandom % 4) == 0;
          e_we[(wr_idx-1) % NSB] = wrsp_err; w_back++;
        end
      end
      wcmd_ready = fast ? 1'b1 : 1'($urandom % 2);
      #1;
      if (wcmd_valid && wcmd_ready) begin
        chk(wcmd_addr == e_wa[wr_idx % NSB], "R2 wr addr", wcmd_addr, e_wa[wr_idx % NSB]);
        chk(wcmd_len == e_ln[wr_idx % NSB], "R2 wr len", wcmd_len, e_ln[wr_idx % NSB]);
        chk(wr_idx == rsp_idx, "R3 wr cmd while prior open", wr_idx, rsp_idx);
        wr_idx++; pend_w = 1 + int'($urandom % 6);
      end
    end
  end

  // response sink
  initial begin
    resp_ready = 0;
    forever begin
      @(negedge clk);
      resp_ready = hold_resp ? 1'b0 : (fast ? 1'b1 : 1'($urandom % 2));
      #1;
      if (resp_valid && resp_ready) begin
        chk(r_back > rsp_idx && w_back > rsp_idx, "R4 resp before both completions", r_back, rsp_idx + 1);
        chk(resp_len == e_ln[rsp_idx % NSB], "R5 resp order/len", resp_len, e_ln[rsp_idx % NSB]);
        chk(resp_err == {e_we[rsp_idx % NSB], e_re[rsp_idx % NSB]}, "R4 resp err",
            resp_err, {e_we[rsp_idx % NSB], e_re[rsp_idx % NSB]});
        rsp_idx++;
      end
    end
  end

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); csr_addr = a; csr_wdata = d; csr_wen = 1;
    @(negedge clk); csr_wen = 0; #1;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic push(input logic [31:0] ra, input logic [31:0] wa, input logic [31:0] ln, input logic [7:0] ct);
    @(negedge clk);
    desc_valid = 1; desc_raddr = ra; desc_waddr = wa; desc_len = ln; desc_ctl = ct;
    #1;
    while (!desc_ready) begin @(negedge clk); #1; end
    e_ra[push_cnt % NSB] = ra; e_wa[push_cnt % NSB] = wa; e_ln[push_cnt % NSB] = ln;
    push_cnt++;
    @(negedge clk); desc_valid = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); csr_read(2'd0, s);
      if (s[0] == 0 && s[1] == 1) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rsp_idx, push_cnt);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    csr_read(2'd0, s);
    chk(s == exp_status(0, 1, 0, 0, 0), "R9 reset status", s, exp_status(0, 1, 0, 0, 0));
    chk(irq == 0 && desc_ready == 1, "R9 reset irq/ready", {irq, desc_ready}, 2'b01);

    // fill: sink stalled, engines fast
    hold_resp = 1; fast = 1;
    for (int i = 0; i < 9; i++) push(32'h1000 + i * 16, 32'h8000 + i * 16, 32'(i + 1), 8'h0);
    repeat (12) @(negedge clk);
    csr_read(2'd2, s);
    chk(s == 8, "R8 level at full", s, 8);
    csr_read(2'd0, s);
    chk(s == exp_status(1, 0, 1, 0, 0), "R1 R8 full status", s, exp_status(1, 0, 1, 0, 0));
    #1; chk(desc_ready == 0, "R1 ready low when full", desc_ready, 0);
    chk(resp_valid == 1 && rcmd_valid == 0 && wcmd_valid == 0, "R3 no cmd while resp open",
        {resp_valid, rcmd_valid, wcmd_valid}, 3'b100);

    // software reset with full queue
    csr_write(2'd1, 32'h1);
    csr_write(2'd1, 32'h3);
    for (int i = 0; i < 4; i++) begin
      csr_read(2'd0, s);
      chk(s[4] == 1, "R7 resetting bit high", s[4], 1);
      @(negedge clk);
    end
    csr_read(2'd0, s);
    chk(s == exp_status(0, 1, 0, 0, 0), "R7 status after reset", s, exp_status(0, 1, 0, 0, 0));
    csr_read(2'd1, s);
    chk(s == 0, "R7 control cleared", s, 0);
    csr_read(2'd2, s);
    chk(s == 0, "R7 queue emptied", s, 0);
    #1; chk(resp_valid == 0 && desc_ready == 1, "R7 idle after reset", {resp_valid, desc_ready}, 2'b01);
    rd_idx = push_cnt; wr_idx = push_cnt; rsp_idx = push_cnt; r_back = push_cnt; w_back = push_cnt;
    hold_resp = 0;

    // interrupt cases
    csr_write(2'd1, 32'h1);
    push(32'hA0, 32'hB0, 32'd64, 8'h1);
    wait_idle();
    csr_read(2'd0, s);
    chk(irq == 1 && s[3] == 1, "R6 irq set on flagged completion", {irq, s[3]}, 2'b11);
    repeat (5) @(negedge clk);
    chk(irq == 1, "R6 irq held", irq, 1);
    csr_write(2'd0, 32'h8);
    chk(irq == 0, "R6 irq cleared by ack", irq, 0);
    push(32'hA4, 32'hB4, 32'd0, 8'h0);
    wait_idle();
    chk(irq == 0, "R6 no irq without ctl bit", irq, 0);
    csr_write(2'd1, 32'h0);
    push(32'hA8, 32'hB8, 32'hFFFF_FFFF, 8'h1);
    wait_idle();
    chk(irq == 0, "R6 no irq when disabled", irq, 0);

    // random traffic
    fast = 0;
    for (int i = 0; i < 30; i++) begin
      push($urandom, $urandom, $urandom % 4096, 8'($urandom));
      repeat ($urandom % 4) @(negedge clk);
    end
    wait_idle();
    chk(rsp_idx == push_cnt, "R5 all responses returned", rsp_idx, push_cnt);
    chk(rd_idx == push_cnt && wr_idx == push_cnt, "R2 one cmd per descriptor", {rd_idx, wr_idx}, {push_cnt, push_cnt});
    csr_read(2'd0, s);
    chk(s == exp_status(0, 1, 0, 0, 0), "R8 final status", s, exp_status(0, 1, 0, 0, 0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule